// File: doc/BRIEF.md
# Host Packet Injection Controller

This block lets a host processor hand one payload packet to a chosen transmit virtual-circuit queue. Software first places the payload in an external 16-bit memory. It then programs a payload length, a base word address and a header word into three descriptor registers. Finally it writes the target circuit number together with a start bit into a control register.

The block then reads the payload words from memory one at a time. It splits each word into bytes, high byte first, and offers the bytes to a queue-append port using a valid/ready handshake. The circuit number and header word travel alongside the bytes. When the final byte has been accepted, the start bit clears by itself, so software can poll the control register to learn that the packet is queued.

Memory reads have a fixed latency of one cycle. The controller handles one packet at a time, and register writes made while a packet is in flight are discarded.

Top module: `cpu_pkt_inject`

## Requirements
- R1: After reset the busy bit (control register bit 15) reads 0, `q_valid` is 0 and `mem_rd` is 0.
- R2: Register offset 0 reads back {busy bit in bit 15, zeros, circuit number in the low `VC_W` bits}. Offsets 1, 2 and 3 read back the payload length in bytes, the payload base word address and the header word.
- R3: Writing offset 0 with bit 15 set while idle latches the circuit number and sets the busy bit. The busy bit stays 1 until the clock edge that accepts the final byte, and clears at that edge.
- R4: Payload words are read from consecutive addresses starting at the base address. From each word, bits 15:8 are sent first and bits 7:0 second.
- R5: For an odd length, the low byte of the final word is not sent. Exactly ceil(length/2) memory reads are issued per packet.
- R6: `q_last` is 1 on the final byte of a packet and 0 on every other byte.
- R7: While `q_valid` is 1 and `q_ready` is 0, `q_valid`, `q_data` and `q_last` hold their values.
- R8: Register writes to any offset while the busy bit is 1 are ignored. This is observable by reading the registers back.
- R9: A start with length 0 issues no memory read and sends no byte. The busy bit reads 1 for exactly one cycle and then clears.
- R10: `q_vc` and `q_hdr` carry the latched circuit number and the header word for every byte of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| mem_rd | output | 1 | Payload memory read strobe |
| mem_addr | output | MEM_AW | Payload memory word address |
| mem_rdata | input | 16 | Payload word, valid one cycle after `mem_rd` |
| q_valid | output | 1 | Byte offered to the queue |
| q_ready | input | 1 | Queue accepts the byte |
| q_data | output | 8 | Payload byte |
| q_last | output | 1 | Final byte of the packet |
| q_vc | output | VC_W | Target circuit number |
| q_hdr | output | 16 | Header word for the packet |

## Verification
The start write takes effect at the first edge. The busy bit is 1 in the following cycle, and `mem_rd` is raised in that same cycle. The memory answers one edge later, and the word is captured one edge after that. As a result, the first byte is offered three edges after the start write. Each later word costs two cycles of fetch before its high byte appears. The busy bit drops at the edge that accepts the last byte; for a zero length it drops at the second edge.

The bench sets `q_ready` and samples the outputs on the falling edge. A byte therefore counts as transferred exactly when both signals are seen high there. The bench polls completion through the register port rather than predicting a cycle count. Only the zero-length case is timed to the cycle.

// File: rtl/cpu_pkt_inject.sv
module cpu_pkt_inject #(
  parameter int VC_W   = 10,
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [7:0]        q_data,
  output logic              q_last,
  output logic [VC_W-1:0]   q_vc,
  output logic [15:0]       q_hdr
);
  localparam int PAD_W = 15 - VC_W;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LATCH, S_HI, S_LO} st_t;

  st_t              st;
  logic             req;
  logic [VC_W-1:0]  vc_r;
  logic [15:0]      len_r, base_r, hdr_r, rem, word;
  logic [MEM_AW-1:0] addr;

  wire end_beat = q_valid && q_ready && (rem == 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      req <= 1'b0;
      vc_r <= '0;
      len_r <= '0;
      base_r <= '0;
      hdr_r <= '0;
      rem <= '0;
      word <= '0;
      addr <= '0;
    end else begin
      if (reg_we && !req) begin
        case (reg_addr)
          2'd0: begin
            vc_r <= reg_wdata[VC_W-1:0];
            if (reg_wdata[15]) begin
              req <= 1'b1;
              st <= S_FETCH;
              rem <= len_r;
              addr <= base_r[MEM_AW-1:0];
            end
          end
          2'd1: len_r <= reg_wdata;
          2'd2: base_r <= reg_wdata;
          default: hdr_r <= reg_wdata;
        endcase
      end
      case (st)
        S_FETCH: begin
          if (rem == 16'd0) begin
            req <= 1'b0;
            st <= S_IDLE;
          end else begin
            st <= S_LATCH;
          end
        end
        S_LATCH: begin
          word <= mem_rdata;
          st <= S_HI;
        end
        S_HI: if (q_ready) begin
          rem <= rem - 16'd1;
          if (end_beat) begin
            req <= 1'b0;
            st <= S_IDLE;
          end else begin
            st <= S_LO;
          end
        end
        S_LO: if (q_ready) begin
          rem <= rem - 16'd1;
          addr <= addr + 1'b1;
          if (end_beat) begin
            req <= 1'b0;
            st <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_rd   = (st == S_FETCH) && (rem != 16'd0);
  assign mem_addr = addr;
  assign q_valid  = (st == S_HI) || (st == S_LO);
  assign q_data   = (st == S_HI) ? word[15:8] : word[7:0];
  assign q_last   = q_valid && (rem == 16'd1);
  assign q_vc     = vc_r;
  assign q_hdr    = hdr_r;

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = {req, {PAD_W{1'b0}}, vc_r};
      2'd1: reg_rdata = len_r;
      2'd2: reg_rdata = base_r;
      default: reg_rdata = hdr_r;
    endcase
  end
endmodule

// File: rtl/cpu_pkt_inject_chk.sv
module cpu_pkt_inject_chk #(
  parameter int VC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            reg_we,
  input logic            q_valid,
  input logic            q_ready,
  input logic [7:0]      q_data,
  input logic            q_last,
  input logic            mem_rd,
  input logic [15:0]     len_r,
  input logic [15:0]     base_r,
  input logic [15:0]     hdr_r,
  input logic [VC_W-1:0] vc_r
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_data) && $stable(q_last));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_last |-> q_valid);

  // R3
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(q_valid && q_ready && q_last) || $past(len_r == 16'd0));

  // R3
  busy_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid || mem_rd) |-> req);

  // R8
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && reg_we |=> $stable(len_r) && $stable(base_r) && $stable(hdr_r) && $stable(vc_r));
endmodule

bind cpu_pkt_inject cpu_pkt_inject_chk #(.VC_W(VC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .reg_we(reg_we),
  .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_last(q_last),
  .mem_rd(mem_rd), .len_r(len_r), .base_r(base_r), .hdr_r(hdr_r), .vc_r(vc_r)
);

// File: tb/cpu_pkt_inject_tb.sv
module cpu_pkt_inject_tb;
  localparam int VC_W = 10;
  localparam int MEM_AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic mem_rd;
  logic [MEM_AW-1:0] mem_addr;
  logic [15:0] mem_rdata = 16'd0;
  logic q_valid, q_last;
  logic q_ready = 1'b0;
  logic [7:0] q_data;
  logic [VC_W-1:0] q_vc;
  logic [15:0] q_hdr;

  always #10 clk = ~clk;

  cpu_pkt_inject #(.VC_W(VC_W), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .q_valid(q_valid),
    .q_ready(q_ready), .q_data(q_data), .q_last(q_last), .q_vc(q_vc), .q_hdr(q_hdr)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ready_mode = 0;
  int nreads = 0;
  logic [VC_W-1:0] exp_vc;
  logic [15:0] exp_hdr;
  logic [8:0] sb[$];

  function automatic logic [15:0] memval(input logic [15:0] a);
    return (a * 16'h1357) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memval({8'd0, mem_addr[7:0]});

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: q_ready = 1'b1;
      1: q_ready = (cyc % 3) != 0;
      default: q_ready = 1'b0;
    endcase
    if (rst_n && mem_rd) nreads++;
    if (rst_n && q_valid && q_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R4 unexpected byte", q_data, 0);
      end else begin
        logic [8:0] e;
        e = sb.pop_front();
        chk(q_data == e[7:0], "R4 byte", q_data, e[7:0]);
        chk(q_last == e[8], "R6 last", q_last, e[8]);
        chk(q_vc == exp_vc && q_hdr == exp_hdr, "R10 tags", {q_vc, q_hdr}, {exp_vc, exp_hdr});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [15:0] d;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, d);
      if (!d[15]) return;
    end
    chk(0, "R3 busy never cleared", 1, 0);
  endtask

  task automatic send_pkt(input logic [VC_W-1:0] vc, input logic [15:0] len,
                          input logic [15:0] base, input logic [15:0] hdr);
    int exp_reads;
    exp_vc = vc;
    exp_hdr = hdr;
    for (int k = 0; k < len; k++) begin
      logic [15:0] w;
      w = memval(base + 16'(k / 2));
      sb.push_back({k == len - 1, (k % 2 == 0) ? w[15:8] : w[7:0]});
    end
    exp_reads = (len + 1) / 2;
    nreads = 0;
    wr(2'd1, len);
    wr(2'd2, base);
    wr(2'd3, hdr);
    wr(2'd0, 16'h8000 | 16'(vc));
    wait_done();
    chk(sb.size() == 0, "R3 bytes left at completion", sb.size(), 0);
    chk(nreads == exp_reads, "R5 read count", nreads, exp_reads);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    #1;
    chk(q_valid == 1'b0 && mem_rd == 1'b0, "R1 outputs in reset", {q_valid, mem_rd}, 0);
    rst_n = 1'b1;
    rd(2'd0, d);
    chk(d[15] == 1'b0, "R1 busy after reset", d[15], 0);

    wr(2'd1, 16'd7);
    wr(2'd2, 16'h0040);
    wr(2'd3, 16'hBEEF);
    wr(2'd0, 16'h0123);
    rd(2'd1, d); chk(d == 16'd7, "R2 length readback", d, 7);
    rd(2'd2, d); chk(d == 16'h0040, "R2 base readback", d, 16'h40);
    rd(2'd3, d); chk(d == 16'hBEEF, "R2 header readback", d, 16'hBEEF);
    rd(2'd0, d); chk(d == 16'h0123, "R2 control readback", d, 16'h123);

    send_pkt(10'h155, 16'd2, 16'h0010, 16'h1111);
    send_pkt(10'h002, 16'd1, 16'h0020, 16'h2222);
    send_pkt(10'h3FF, 16'd25, 16'h0030, 16'h3333);
    ready_mode = 1;
    send_pkt(10'h0AA, 16'd12, 16'h0080, 16'h4444);
    send_pkt(10'h011, 16'd9, 16'h00F8, 16'h5555);
    ready_mode = 0;

    // R8: writes during a stalled packet
    ready_mode = 2;
    exp_vc = 10'h066; exp_hdr = 16'h6666;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = memval(16'h0050 + 16'(k / 2));
      sb.push_back({k == 3, (k % 2 == 0) ? w[15:8] : w[7:0]});
    end
    nreads = 0;
    wr(2'd1, 16'd4);
    wr(2'd2, 16'h0050);
    wr(2'd3, 16'h6666);
    wr(2'd0, 16'h8066);
    repeat (5) @(negedge clk);
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'h0BAD);
    wr(2'd0, 16'h8005);
    rd(2'd1, d); chk(d == 16'd4, "R8 length held", d, 4);
    rd(2'd3, d); chk(d == 16'h6666, "R8 header held", d, 16'h6666);
    rd(2'd0, d); chk(d == 16'h8066, "R8 control held", d, 16'h8066);
    ready_mode = 0;
    wait_done();
    chk(sb.size() == 0, "R3 bytes left at completion", sb.size(), 0);
    chk(nreads == 2, "R5 read count", nreads, 2);

    // R9: zero length
    wr(2'd1, 16'd0);
    nreads = 0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h8009;
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk(reg_rdata[15] == 1'b1, "R9 busy one cycle", reg_rdata[15], 1);
    @(negedge clk);
    #1 chk(reg_rdata[15] == 1'b0, "R9 busy cleared", reg_rdata[15], 0);
    repeat (3) @(negedge clk);
    chk(nreads == 0 && sb.size() == 0, "R9 no reads or bytes", nreads, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule